// File: doc/BRIEF.md
# External Bus Turnaround Wait Scheduler

This block sits between an access arbiter and the sequencer that drives an external static-memory bus. Each cycle it decides whether the access the arbiter is presenting may start now or must be held. To decide, it keeps a record of the last external access: whether it was a read or a write, and which chip select it used. From that record it inserts three kinds of idle cycle. Bus-release (float) cycles give a slow device time to stop driving the data bus after a read. A read-to-write cycle separates a read from a following write. A reload cycle is added whenever the slow clock mode setting changes.

Each chip select has its own configuration: a float count of 0 to 15 cycles, a bit that chooses which strobe edge starts the float period, and a flag that makes the float period apply even to a repeated read of the same device. The sequencer reports the rising edges of the read strobe and of the chip select as one-cycle pulses. Requests to internal memory never wait. The arbiter holds a request, with its fields stable, until `grant` is seen high in the same cycle.

Top module: `bus_turn_sched`

## Requirements
- R1: After reset no previous access is on record and every counter is zero, so the first external request is granted in the cycle it is presented. With no request present, `grant` is low.
- R2: A request with `req_internal` high is granted in the cycle it is presented, even while a float count is running or a reload is pending.
- R3: After an external read, a read to a different chip select is held for the float count N of the read's chip select. Counting starts at the selected edge pulse in cycle e, and the request is granted in cycle e+1+N. Before the edge pulse arrives, the request is held.
- R4: After an external read, a write to any chip select waits for the float period and then for one further read-to-write cycle, so it is granted in cycle e+2+N. A read after a write, and a write after a write, are granted at once.
- R5: After a read, a further read to the same chip select is granted at once when that chip select's `cfg_strict` bit is 0. When the bit is 1, the request waits the full float period.
- R6: When the `cfg_rd_ctl` bit of the read's chip select is 1, only `rd_strobe_rise` starts the float period. When the bit is 0, only `cs_rise` starts it. A pulse on the other input leaves the request held.
- R7: The float count keeps running through idle and internal cycles. A request presented k cycles after the edge pulse waits max(N-k, 0) cycles for the float period.
- R8: A change of the level on `slow_mode`, in either direction, adds one stall cycle before the next external access. This cycle is added even between two writes.
- R9: When float, read-to-write and reload waits are all due, they are served in that order, one after another, with `grant` low throughout. A write after a read, with slow mode toggled, is therefore granted in cycle e+3+N.
- R10: `grant` is high only in a cycle where `req_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_float_cyc | input | NCS*CNT_W | Float count per chip select, chip select c at bits c*CNT_W upward |
| cfg_rd_ctl | input | NCS | Per chip select: 1 starts float at read strobe rise, 0 at chip select rise |
| cfg_strict | input | NCS | Per chip select: 1 enforces float before any following external access |
| slow_mode | input | 1 | Slow clock mode level; each change costs one reload cycle |
| rd_strobe_rise | input | 1 | One-cycle pulse: read strobe of the last access rose |
| cs_rise | input | 1 | One-cycle pulse: chip select of the last access rose |
| req_valid | input | 1 | Access request present |
| req_internal | input | 1 | Request targets internal memory |
| req_write | input | 1 | Request is a write (0 = read) |
| req_cs | input | CS_W | Chip select of the request |
| grant | output | 1 | Request may start this cycle |

## Verification
Some properties hold on every cycle, and the assertions check those: grant only appears with a request, internal requests go through at once, the first external request after reset is free, a slow-mode change blocks an external grant in that cycle, and a write is never granted in the cycle straight after a read grant. The exact wait length depends on the float count, the edge-select bit, the strict flag and how many cycles have already passed. Only the bench's sweep over every float count and both edge modes can show those lengths, by comparing each measured wait with one computed from the pulse cycle.

// File: rtl/bts_pkg.sv
package bts_pkg;
   typedef enum logic [1:0] {
      STG_CLEAR  = 2'd0,
      STG_FLOAT  = 2'd1,
      STG_RTW    = 2'd2,
      STG_RELOAD = 2'd3
   } stall_e;

   function automatic int idx_width(input int n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/bts_cfg_sel.sv
module bts_cfg_sel #(
   parameter int NCS       = 4,
   parameter int CNT_W     = 4,
   parameter bit STRICT_EN = 1'b1,
   localparam int CS_W     = bts_pkg::idx_width(NCS)
) (
   input  logic [NCS*CNT_W-1:0] float_flat,
   input  logic [NCS-1:0]       rd_ctl_vec,
   input  logic [NCS-1:0]       strict_vec,
   input  logic [CS_W-1:0]      sel,
   output logic [CNT_W-1:0]     sel_float,
   output logic                 sel_rd_ctl,
   output logic                 sel_strict
);
   logic [CNT_W-1:0] float_arr [NCS];
   logic             strict_eff [NCS];

   for (genvar c = 0; c < NCS; c++) begin : g_cs
      assign float_arr[c] = float_flat[c*CNT_W +: CNT_W];
      if (STRICT_EN) begin : g_strict
         assign strict_eff[c] = strict_vec[c];
      end else begin : g_nostrict
         assign strict_eff[c] = 1'b0;
      end
   end

   always_comb begin
      sel_float  = '0;
      sel_rd_ctl = 1'b0;
      sel_strict = 1'b0;
      if (int'(sel) < NCS) begin
         sel_float  = float_arr[sel];
         sel_rd_ctl = rd_ctl_vec[sel];
         sel_strict = strict_eff[sel];
      end
   end
endmodule

// File: rtl/bts_history.sv
module bts_history #(
   parameter int CS_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rec_en,
   input  logic            rec_write,
   input  logic [CS_W-1:0] rec_cs,
   output logic            last_valid,
   output logic            last_read,
   output logic [CS_W-1:0] last_cs
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_valid <= 1'b0;
         last_read  <= 1'b0;
         last_cs    <= '0;
      end else if (rec_en) begin
         last_valid <= 1'b1;
         last_read  <= ~rec_write;
         last_cs    <= rec_cs;
      end
   end
endmodule

// File: rtl/bts_float_timer.sv
module bts_float_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             arm,
   input  logic             edge_seen,
   input  logic [CNT_W-1:0] load_val,
   output logic             released
);
   logic             armed_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         cnt_q   <= '0;
      end else if (arm) begin
         armed_q <= 1'b1;
         cnt_q   <= '0;
      end else if (armed_q && edge_seen) begin
         armed_q <= 1'b0;
         cnt_q   <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q   <= cnt_q - 1'b1;
      end
   end

   assign released = !armed_q && (cnt_q == '0);
endmodule

// File: rtl/bts_stall_seq.sv
module bts_stall_seq
   import bts_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic ext_req,
   input  logic need_float,
   input  logic need_rtw,
   input  logic slow_mode,
   output logic ext_go
);
   logic   slow_q, rld_pend_q, rtw_done_q;
   logic   slow_flip, rld_need;
   stall_e stage;

   assign slow_flip = slow_mode ^ slow_q;
   assign rld_need  = rld_pend_q | slow_flip;

   always_comb begin
      stage = STG_CLEAR;
      if (need_float)                    stage = STG_FLOAT;
      else if (need_rtw && !rtw_done_q)  stage = STG_RTW;
      else if (rld_need)                 stage = STG_RELOAD;
   end

   assign ext_go = ext_req && (stage == STG_CLEAR);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slow_q     <= 1'b0;
         rld_pend_q <= 1'b0;
         rtw_done_q <= 1'b0;
      end else begin
         slow_q <= slow_mode;
         if (ext_req && stage == STG_RELOAD) rld_pend_q <= 1'b0;
         else if (slow_flip)                 rld_pend_q <= 1'b1;
         if (!ext_req || ext_go)             rtw_done_q <= 1'b0;
         else if (stage == STG_RTW)          rtw_done_q <= 1'b1;
      end
   end
endmodule

// File: rtl/bus_turn_sched.sv
module bus_turn_sched #(
   parameter int NCS       = 4,
   parameter int CNT_W     = 4,
   parameter bit STRICT_EN = 1'b1,
   localparam int CS_W     = bts_pkg::idx_width(NCS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NCS*CNT_W-1:0] cfg_float_cyc,
   input  logic [NCS-1:0]       cfg_rd_ctl,
   input  logic [NCS-1:0]       cfg_strict,
   input  logic                 slow_mode,
   input  logic                 rd_strobe_rise,
   input  logic                 cs_rise,
   input  logic                 req_valid,
   input  logic                 req_internal,
   input  logic                 req_write,
   input  logic [CS_W-1:0]      req_cs,
   output logic                 grant
);
   if (NCS < 1) begin : g_chk_ncs
      $error("bus_turn_sched: NCS must be at least 1");
   end
   if (CNT_W < 1 || CNT_W > 16) begin : g_chk_cnt
      $error("bus_turn_sched: CNT_W must lie in 1..16");
   end

   logic            last_valid, last_read;
   logic [CS_W-1:0] last_cs;
   logic [CNT_W-1:0] last_float;
   logic            last_rd_ctl, last_strict;
   logic            ext_req, ext_go, released, edge_seen;
   logic            float_due, need_float, need_rtw, rec_en;

   assign ext_req = req_valid & ~req_internal;
   assign grant   = req_valid & (req_internal | ext_go);
   assign rec_en  = ext_req & ext_go;

   bts_history #(.CS_W(CS_W)) u_hist (
      .clk(clk), .rst_n(rst_n),
      .rec_en(rec_en), .rec_write(req_write), .rec_cs(req_cs),
      .last_valid(last_valid), .last_read(last_read), .last_cs(last_cs)
   );

   bts_cfg_sel #(.NCS(NCS), .CNT_W(CNT_W), .STRICT_EN(STRICT_EN)) u_cfg (
      .float_flat(cfg_float_cyc), .rd_ctl_vec(cfg_rd_ctl),
      .strict_vec(cfg_strict), .sel(last_cs),
      .sel_float(last_float), .sel_rd_ctl(last_rd_ctl), .sel_strict(last_strict)
   );

   assign edge_seen = last_rd_ctl ? rd_strobe_rise : cs_rise;

   bts_float_timer #(.CNT_W(CNT_W)) u_float (
      .clk(clk), .rst_n(rst_n),
      .arm(rec_en & ~req_write), .edge_seen(edge_seen),
      .load_val(last_float), .released(released)
   );

   assign float_due  = last_valid & last_read &
                       (req_write | (req_cs != last_cs) | last_strict);
   assign need_float = float_due & ~released;
   assign need_rtw   = last_valid & last_read & req_write;

   bts_stall_seq u_seq (
      .clk(clk), .rst_n(rst_n), .ext_req(ext_req),
      .need_float(need_float), .need_rtw(need_rtw),
      .slow_mode(slow_mode), .ext_go(ext_go)
   );
endmodule

// File: rtl/bus_turn_sched_chk.sv
module bus_turn_sched_chk (
   input logic clk,
   input logic rst_n,
   input logic req_valid,
   input logic req_internal,
   input logic req_write,
   input logic slow_mode,
   input logic grant
);
   logic seen_ext_q, prev_rd_grant_q, prev_slow_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_ext_q      <= 1'b0;
         prev_rd_grant_q <= 1'b0;
         prev_slow_q     <= 1'b0;
      end else begin
         prev_slow_q     <= slow_mode;
         prev_rd_grant_q <= grant & req_valid & ~req_internal & ~req_write;
         if ((grant && !req_internal) || (slow_mode != prev_slow_q))
            seen_ext_q <= 1'b1;
      end
   end

   AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      grant |-> req_valid); // R10
   AST_INTERNAL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_internal) |-> grant); // R2
   AST_FIRST_EXT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_internal && !seen_ext_q && slow_mode == prev_slow_q) |-> grant); // R1
   AST_RELOAD_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_internal && slow_mode != prev_slow_q) |-> !grant); // R8
   AST_RTW_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (grant && !req_internal && req_write) |-> !prev_rd_grant_q); // R4
endmodule

bind bus_turn_sched bus_turn_sched_chk u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_internal(req_internal),
   .req_write(req_write), .slow_mode(slow_mode), .grant(grant)
);

// File: tb/sim_bus_turn_sched.sv
module sim_bus_turn_sched;
   localparam int NCS = 4;
   localparam int CNT_W = 4;
   localparam int CS_W = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [NCS*CNT_W-1:0] cfg_float_cyc = '0;
   logic [NCS-1:0] cfg_rd_ctl = '0;
   logic [NCS-1:0] cfg_strict = '0;
   logic slow_mode = 1'b0, rd_strobe_rise = 1'b0, cs_rise = 1'b0;
   logic req_valid = 1'b0, req_internal = 1'b0, req_write = 1'b0;
   logic [CS_W-1:0] req_cs = '0;
   logic grant;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   bus_turn_sched #(.NCS(NCS), .CNT_W(CNT_W)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_float_cyc(cfg_float_cyc),
      .cfg_rd_ctl(cfg_rd_ctl), .cfg_strict(cfg_strict), .slow_mode(slow_mode),
      .rd_strobe_rise(rd_strobe_rise), .cs_rise(cs_rise), .req_valid(req_valid),
      .req_internal(req_internal), .req_write(req_write), .req_cs(req_cs),
      .grant(grant)
   );

   task automatic check(input int got, input int exp, input string req);
      checks++;
      if (got != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
      end
   endtask

   // Called just after a falling edge; returns just after a falling edge.
   task automatic access(input bit intl, input bit wr, input int cs, output int waits);
      req_valid = 1'b1; req_internal = intl; req_write = wr; req_cs = CS_W'(cs);
      waits = 0;
      for (int i = 0; i < 60; i++) begin
         #1;
         if (grant) break;
         @(negedge clk);
         waits++;
      end
      @(negedge clk);
      req_valid = 1'b0; req_internal = 1'b0; req_write = 1'b0;
   endtask

   task automatic pulse(input bit strobe);
      if (strobe) rd_strobe_rise = 1'b1; else cs_rise = 1'b1;
      @(negedge clk);
      rd_strobe_rise = 1'b0; cs_rise = 1'b0;
   endtask

   task automatic settle();
      pulse(1'b1); pulse(1'b0);
      repeat (18) @(negedge clk);
   endtask

   initial begin
      int w;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1 check(int'(grant), 0, "R10 idle grant");
      @(negedge clk);
      access(1'b0, 1'b0, 0, w); check(w, 0, "R1 first request");
      settle();
      for (int n = 0; n < 16; n++) begin
         for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < NCS; c++) begin
               cfg_float_cyc[c*CNT_W +: CNT_W] = CNT_W'(n);
               cfg_rd_ctl[c] = m[0];
            end
            cfg_strict = 4'b0100;
            // R3 read then read other chip select
            access(0, 0, 0, w); pulse(m[0]); access(0, 0, 1, w);
            check(w, n, "R3 read to other cs"); settle();
            // R4 read then write
            access(0, 0, 0, w); pulse(m[0]); access(0, 1, 0, w);
            check(w, n + 1, "R4 read to write");
            access(0, 0, 3, w); check(w, 0, "R4 write to read");
            settle();
            access(0, 1, 1, w); access(0, 1, 2, w); check(w, 0, "R4 write to write");
            // R5 same cs reads
            access(0, 0, 0, w); pulse(m[0]); access(0, 0, 0, w);
            check(w, 0, "R5 same cs non-strict"); settle();
            access(0, 0, 2, w); pulse(m[0]); access(0, 0, 2, w);
            check(w, n, "R5 same cs strict"); settle();
            // R6 wrong edge ignored
            access(0, 0, 0, w); pulse(~m[0]);
            req_valid = 1'b1; req_internal = 1'b0; req_write = 1'b0; req_cs = 2'd1;
            begin
               int hi = 0;
               for (int k = 0; k < 3; k++) begin
                  #1; if (grant) hi++;
                  @(negedge clk);
               end
               req_valid = 1'b0;
               check(hi, 0, "R6 other edge ignored");
            end
            pulse(m[0]); access(0, 0, 1, w);
            check(w, n, "R6 selected edge starts float"); settle();
            // R7 idle credit
            access(0, 0, 0, w); pulse(m[0]);
            repeat (n / 2) @(negedge clk);
            access(0, 0, 1, w); check(w, n - n / 2, "R7 partial credit"); settle();
            access(0, 0, 0, w); pulse(m[0]);
            repeat (n) @(negedge clk);
            access(0, 1, 1, w); check(w, 1, "R7 full credit then rtw");
            // R2 internal during countdown
            access(0, 0, 0, w); pulse(m[0]); access(1, 0, 0, w);
            check(w, 0, "R2 internal bypass");
            access(0, 0, 1, w); check(w, (n > 0) ? n - 1 : 0, "R7 credit across internal");
            settle();
            // R9 all waits combined
            access(0, 0, 0, w); slow_mode = ~slow_mode; pulse(m[0]);
            access(0, 1, 1, w); check(w, n + 3 - 1, "R9 float+rtw+reload");
            // R8 reload alone and internal bypass
            slow_mode = ~slow_mode; @(negedge clk);
            access(1, 1, 0, w); check(w, 0, "R2 internal with reload pending");
            access(0, 1, 2, w); check(w, 1, "R8 reload between writes");
            access(0, 1, 2, w); check(w, 0, "R8 reload served once");
         end
      end
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #(4 * 150000);
      if (!done) begin
         done = 1'b1;
         checks++; fails++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule